// File: doc/BRIEF.md
# Exhausted Cut-Through Crossbar Switch

A four-port packet switch with a queue on each input and a crossbar between the inputs and the outputs. Packets are routed by their source. The low two bits of the head flit's data name the output to leave by. The switch removes those two bits by shifting the head data right, so the next hop finds its own route field in the low bits. A packet heading for an idle output is forwarded flit by flit as it arrives. The switch does not wait for the whole packet first.

When the output a packet wants is busy, the input keeps taking flits into its 16-entry queue for as long as there is room. Only after the queue fills does the input drop its ready line and hold the upstream link, in the way a wormhole network holds a channel. A separate stop line warns the upstream sender early: it goes high once four or fewer entries are free, so flits already on the wire still have room to land. Each output has its own round-robin arbiter. The arbiter picks a winner in the same cycle that the requests appear, and it stays locked to that input from the head flit to the tail flit. The starting priority of each arbiter is set by a parameter.

A flit is 8 data bits with a head flag and a tail flag. A single-flit packet carries both flags.

Top module: `ect_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, every output valid is low, every input ready is high and every stop line is low.
- R2: A head flit with data d leaves on output d[1:0] carrying data d>>2, with zeros in the top two bits. Body and tail flit data leave unchanged. Head and tail flags are passed through as they arrive.
- R3: Each output grants the first requesting input found by counting upward (modulo 4) from its priority pointer. After the tail flit of a granted packet leaves, the pointer moves to the winner plus one.
- R4: A flit accepted at a clock edge is presented on a free output in the very next cycle (cut-through).
- R5: While its packet is blocked, an input accepts flits until 16 are stored. Its ready line is low exactly when all 16 entries are full, and no flit is lost while the link is held.
- R6: An input's stop line is high exactly when 4 or fewer of its 16 entries are free.
- R7: An output stays locked to one input from the head flit to the tail flit. While the owning input has no flit stored, the output stays idle and other inputs wait.
- R8: After reset each output's priority pointer holds the 2-bit field at bits [2o+1:2o] of the INIT_PRI parameter.
- R9: Packets from different inputs to different outputs are forwarded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 4 | Per-input flit valid |
| in_head | input | 4 | Per-input head flag |
| in_tail | input | 4 | Per-input tail flag |
| in_data | input | 32 | Per-input flit data, input i at bits [8i+7:8i] |
| in_ready | output | 4 | Input queue has room; a flit is taken when valid and ready are both high |
| in_stop | output | 4 | Slack stop: 4 or fewer free entries |
| out_valid | output | 4 | Per-output flit valid |
| out_head | output | 4 | Per-output head flag |
| out_tail | output | 4 | Per-output tail flag |
| out_data | output | 32 | Per-output flit data, output o at bits [8o+7:8o] |
| out_ready | input | 4 | Downstream accepts the flit on this output |

## Verification
The bench builds the switch with 4 ports, 8-bit data, a 16-entry queue and a slack of 4. INIT_PRI gives each output a different starting pointer (3, 2, 0 and 1), so the first grant after reset shows that the parameter was loaded and not a fixed zero. With a queue only 16 deep, a blocked input reaches both the early stop point and the full-queue hold within a few cycles. Long random phases with out_ready held low much of the time then keep queues near full and locks contended on every output.

// File: rtl/ect_switch.sv
module ect_switch #(
  parameter int NP    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int SLACK = 4,
  parameter logic [NP*$clog2(NP)-1:0] INIT_PRI = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   in_valid,
  input  logic [NP-1:0]   in_head,
  input  logic [NP-1:0]   in_tail,
  input  logic [NP*DW-1:0] in_data,
  output logic [NP-1:0]   in_ready,
  output logic [NP-1:0]   in_stop,
  output logic [NP-1:0]   out_valid,
  output logic [NP-1:0]   out_head,
  output logic [NP-1:0]   out_tail,
  output logic [NP*DW-1:0] out_data,
  input  logic [NP-1:0]   out_ready
);
  localparam int PW = $clog2(NP);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int FW = DW + 2;

  logic [FW-1:0] mem [NP][DEPTH];
  logic [AW-1:0] rp [NP];
  logic [AW-1:0] wp [NP];
  logic [CW-1:0] cnt [NP];
  logic [FW-1:0] front [NP];
  logic [NP-1:0] push, pop, nonempty;

  logic [NP-1:0] req [NP];
  logic [PW-1:0] win [NP];
  logic [PW-1:0] sel [NP];
  logic [PW-1:0] owner [NP];
  logic [PW-1:0] pri [NP];
  logic [NP-1:0] hit, lock, fire;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      front[i]    = mem[i][rp[i]];
      nonempty[i] = cnt[i] != '0;
      in_ready[i] = cnt[i] != CW'(DEPTH);
      in_stop[i]  = (CW'(DEPTH) - cnt[i]) <= CW'(SLACK);
      push[i]     = in_valid[i] & in_ready[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (push[i]) mem[i][wp[i]] <= {in_head[i], in_tail[i], in_data[i*DW +: DW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        rp[i]  <= '0;
        wp[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (push[i]) wp[i] <= wp[i] + AW'(1);
        if (pop[i])  rp[i] <= rp[i] + AW'(1);
        cnt[i] <= cnt[i] + CW'(push[i]) - CW'(pop[i]);
      end
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NP; o++) begin
      logic [PW-1:0] cand;
      logic [FW-1:0] fl;
      for (int i = 0; i < NP; i++)
        req[o][i] = nonempty[i] & front[i][DW+1] & (front[i][PW-1:0] == PW'(o));
      win[o] = pri[o];
      hit[o] = 1'b0;
      for (int k = NP - 1; k >= 0; k--) begin
        cand = pri[o] + PW'(k);
        if (req[o][cand]) begin
          win[o] = cand;
          hit[o] = 1'b1;
        end
      end
      sel[o]       = lock[o] ? owner[o] : win[o];
      out_valid[o] = lock[o] ? nonempty[owner[o]] : hit[o];
      fl           = front[sel[o]];
      out_head[o]  = fl[DW+1];
      out_tail[o]  = fl[DW];
      out_data[o*DW +: DW] = fl[DW+1] ? {PW'(0), fl[DW-1:PW]} : fl[DW-1:0];
      fire[o]      = out_valid[o] & out_ready[o];
      if (fire[o]) pop[sel[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NP; o++) begin
        lock[o]  <= 1'b0;
        owner[o] <= '0;
        pri[o]   <= INIT_PRI[o*PW +: PW];
      end
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (fire[o]) begin
          if (out_tail[o]) begin
            lock[o] <= 1'b0;
            pri[o]  <= sel[o] + PW'(1);
          end else if (out_head[o]) begin
            lock[o]  <= 1'b1;
            owner[o] <= sel[o];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ect_switch_chk.sv
module ect_switch_chk #(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] in_ready,
  input logic [NP-1:0] in_stop,
  input logic [NP-1:0] out_valid,
  input logic [NP-1:0] out_ready,
  input logic [NP-1:0] out_head,
  input logic [NP-1:0] out_tail,
  input logic [NP-1:0] lock,
  input logic [PW-1:0] owner [NP]
);
  for (genvar i = 0; i < NP; i++) begin : g_in
    a_r6_full_implies_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready[i] |-> in_stop[i]);
    a_r5_stop_warns_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready[i]) |-> $past(in_stop[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    a_r1_idle_in_reset: assert property (@(posedge clk)
      !rst_n |=> !out_valid[o]);
    a_r7_lock_on_head: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && out_ready[o] && out_head[o] && !out_tail[o] |=> lock[o]);
    a_r7_free_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && out_ready[o] && out_tail[o] |=> !lock[o]);
    a_r7_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
      lock[o] && !(out_valid[o] && out_ready[o] && out_tail[o]) |=> lock[o] && $stable(owner[o]));
    for (genvar p = o + 1; p < NP; p++) begin : g_pair
      a_r7_distinct_owner: assert property (@(posedge clk) disable iff (!rst_n)
        lock[o] && lock[p] |-> owner[o] != owner[p]);
    end
  end
endmodule

bind ect_switch ect_switch_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_stop(in_stop),
  .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
  .out_tail(out_tail), .lock(lock), .owner(owner)
);

// File: tb/ect_switch_bench.sv
`timescale 1ns/1ps
module ect_switch_bench;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int SLACK = 4;
  localparam logic [7:0] INIT = 8'b01_00_10_11;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0] in_valid, in_head, in_tail, in_ready, in_stop;
  logic [NP-1:0] out_valid, out_head, out_tail, out_ready;
  logic [NP*DW-1:0] in_data, out_data;

  always #4 clk = ~clk;

  ect_switch #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .SLACK(SLACK), .INIT_PRI(INIT)) u_ect_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
    .in_data(in_data), .in_ready(in_ready), .in_stop(in_stop), .out_valid(out_valid),
    .out_head(out_head), .out_tail(out_tail), .out_data(out_data), .out_ready(out_ready)
  );

  int compared = 0;
  int mism = 0;
  logic [9:0] src_q [NP][$];
  logic [9:0] mq [NP][$];
  bit mlock [NP];
  int mown [NP];
  int mpri [NP];
  int vprob = 100;
  int rprob = 100;
  bit use_fixed = 1'b1;
  logic [NP-1:0] fixed_rdy = '0;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mism++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_pkt(int i, int d, int len);
    for (int n = 0; n < len; n++) begin
      logic [7:0] b = 8'($urandom_range(255));
      if (n == 0) b[1:0] = 2'(d);
      src_q[i].push_back({n == 0, n == len - 1, b});
    end
  endtask

  task automatic run_cycle();
    int sz [NP];
    int esel [NP];
    bit ev [NP];
    for (int i = 0; i < NP; i++) begin
      bit v = (src_q[i].size() > 0) && ($urandom_range(99) < vprob);
      in_valid[i] = v;
      {in_head[i], in_tail[i], in_data[i*DW +: DW]} = v ? src_q[i][0] : 10'd0;
    end
    for (int o = 0; o < NP; o++)
      out_ready[o] = use_fixed ? fixed_rdy[o] : ($urandom_range(99) < rprob);
    #1;
    for (int i = 0; i < NP; i++) begin
      sz[i] = mq[i].size();
      chk("R5 in_ready", in_ready[i], sz[i] < DEPTH);
      chk("R6 in_stop", in_stop[i], (DEPTH - sz[i]) <= SLACK);
    end
    for (int o = 0; o < NP; o++) begin
      bit found = 1'b0;
      int w = 0;
      for (int k = 0; k < NP; k++) begin
        int idx = (mpri[o] + k) % NP;
        if (!found && mq[idx].size() > 0 && mq[idx][0][9] && mq[idx][0][1:0] == 2'(o)) begin
          found = 1'b1;
          w = idx;
        end
      end
      esel[o] = mlock[o] ? mown[o] : w;
      ev[o] = mlock[o] ? (mq[esel[o]].size() > 0) : found;
      chk("R3/R7 out_valid", out_valid[o], ev[o]);
      if (ev[o]) begin
        logic [9:0] fl = mq[esel[o]][0];
        chk("R2 out_data", out_data[o*DW +: DW], fl[9] ? {2'b00, fl[7:2]} : fl[7:0]);
        chk("R2 out_head", out_head[o], fl[9]);
        chk("R2 out_tail", out_tail[o], fl[8]);
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (ev[o] && out_ready[o]) begin
        logic [9:0] fl = mq[esel[o]].pop_front();
        if (fl[8]) begin
          mlock[o] = 1'b0;
          mpri[o] = (esel[o] + 1) % NP;
        end else if (fl[9]) begin
          mlock[o] = 1'b1;
          mown[o] = esel[o];
        end
      end
    end
    for (int i = 0; i < NP; i++)
      if (in_valid[i] && sz[i] < DEPTH) mq[i].push_back(src_q[i].pop_front());
    @(negedge clk);
  endtask

  task automatic random_phase(int cycles, int vp, int rp, int hot);
    use_fixed = 1'b0;
    vprob = vp;
    rprob = rp;
    for (int c = 0; c < cycles; c++) begin
      for (int i = 0; i < NP; i++)
        if (src_q[i].size() == 0 && $urandom_range(3) == 0)
          add_pkt(i, hot < 0 ? int'($urandom_range(3)) : hot, int'($urandom_range(1, 6)));
      run_cycle();
    end
    vprob = 100;
    rprob = 100;
    for (int c = 0; c < 300; c++) run_cycle();
    for (int i = 0; i < NP; i++) chk("R5 drained", mq[i].size() + src_q[i].size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mism++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_head = '0; in_tail = '0; in_data = '0; out_ready = '0;
    for (int o = 0; o < NP; o++) begin
      mlock[o] = 1'b0;
      mown[o] = 0;
      mpri[o] = int'(INIT[o*2 +: 2]);
    end
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 4'hF);
    rst_n = 1'b1;
    chk("R1 in_stop after reset", in_stop, 0);

    // R8 / R3: four single-flit packets race for output 0, pointer starts at 3
    fixed_rdy = 4'b0000;
    for (int i = 0; i < NP; i++) src_q[i].push_back({2'b11, 6'(i), 2'b00});
    run_cycle();
    chk("R8 out_valid[0]", out_valid[0], 1);
    fixed_rdy = 4'b0001;
    for (int k = 0; k < NP; k++) begin
      chk("R8/R3 winner order", out_data[7:0], (3 + k) % NP);
      run_cycle();
    end
    chk("R3 output 0 idle", out_valid[0], 0);

    // R4 / R2 / R9: two inputs to two outputs at once
    fixed_rdy = 4'b1111;
    src_q[1].push_back({2'b10, 8'hB6});
    src_q[1].push_back({2'b01, 8'h5A});
    src_q[3].push_back({2'b11, 8'h3D});
    run_cycle();
    chk("R4 cut-through valid", out_valid[2], 1);
    chk("R2 head stripped", out_data[23:16], 8'h2D);
    chk("R9 parallel valid", out_valid[1], 1);
    chk("R9 parallel data", out_data[15:8], 8'h0F);
    run_cycle();
    chk("R2 tail unchanged", out_data[23:16], 8'h5A);
    chk("R2 tail flag", out_tail[2], 1);
    chk("R2 body head flag", out_head[2], 0);
    repeat (3) run_cycle();

    // R5 / R6: output 1 blocked, long packet on input 0
    fixed_rdy = 4'b1101;
    add_pkt(0, 1, 24);
    repeat (11) run_cycle();
    chk("R6 stop low at 5 free", in_stop[0], 0);
    run_cycle();
    chk("R6 stop high at 4 free", in_stop[0], 1);
    chk("R5 still accepting", in_ready[0], 1);
    repeat (4) run_cycle();
    chk("R5 ready low when full", in_ready[0], 0);
    repeat (3) run_cycle();
    chk("R5 link held", src_q[0].size(), 8);
    chk("R5 blocked head offered", out_valid[1], 1);
    fixed_rdy = 4'b1111;
    repeat (40) run_cycle();
    chk("R5 released", src_q[0].size() + mq[0].size(), 0);

    // R7: output 3 locked to input 1 through a bubble
    src_q[1].push_back({2'b10, 8'h47});
    src_q[1].push_back({2'b00, 8'hA1});
    src_q[0].push_back({2'b11, 8'h83});
    run_cycle();
    chk("R7 first winner", out_data[31:24], 8'h11);
    run_cycle();
    chk("R7 body follows", out_data[31:24], 8'hA1);
    run_cycle();
    chk("R7 idle in bubble", out_valid[3], 0);
    src_q[1].push_back({2'b01, 8'hC2});
    run_cycle();
    chk("R7 tail from owner", out_data[31:24], 8'hC2);
    chk("R7 tail flag", out_tail[3], 1);
    run_cycle();
    chk("R7 waiting input next", out_data[31:24], 8'h20);
    repeat (3) run_cycle();

    random_phase(1500, 70, 80, -1);
    random_phase(1500, 90, 25, -1);
    random_phase(1000, 90, 50, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule